// File: doc/BRIEF.md
# Two-Lane to Byte-Wide GMII Converter

This block takes a transmit stream in which each 16-bit word carries two GMII bytes and turns it into a plain 8-bit GMII byte stream. Every output byte has its own valid and error flag, and the output is paced by a clock-enable strobe whose rate follows a 2-bit speed select. At gigabit rate the strobe is high on every cycle. At 100 Mbps it fires on every tenth cycle, and at 10 Mbps on every hundredth cycle. This lets one fast clock serve all three line rates.

Words come in through a ready/accept handshake. A word that fills both lanes takes two strobes: the low lane goes out first and the high lane at the next strobe. A word that fills only the low lane takes one strobe, so a frame can end on either lane. The block also drives a constant latency word that a timestamping unit can use, with whole cycles in the upper field and a binary fraction of a cycle in the lower field.

Top module: `gmii_lane_splitter`

## Requirements
- R1: A word with enable 2'b11 is emitted as two bytes. Bits [7:0] go out at the strobe that accepts the word, and bits [15:8] go out at the next strobe.
- R2: The strobe `clk_ena` is high on every cycle when `speed_sel` is 2'b10 or 2'b11. It is high on one cycle in every 10 for 2'b01 and on one cycle in every 100 for 2'b00.
- R3: `in_ready` is high only in a cycle whose closing edge is a strobe while no high-lane byte is pending. A word present in such a cycle is taken at that edge. After a two-lane word is taken, `in_ready` stays low until the high byte has been emitted.
- R4: Each emitted byte carries the error bit of its own lane: `in_err[0]` for the low byte and `in_err[1]` for the high byte.
- R5: `out_valid` is high only in cycles where `clk_ena` is high. It is high for exactly one cycle per emitted byte.
- R6: `out_data` and `out_err` keep their values on every cycle in which `clk_ena` is low.
- R7: A word with enable 2'b01 emits only its low byte, and `in_ready` is high again at the next strobe.
- R8: A word with enable 2'b10 (high lane without low lane) is consumed without effect. `out_valid` stays low, `out_data` is unchanged, and `in_ready` is high at the next strobe.
- R9: A change of `speed_sel` restarts the rate counter. The first strobe at the new rate comes on the P-th edge after the edge that sees the change, where P is 1, 10 or 100.
- R10: While `rst` is high, `out_valid`, `out_err`, `out_data` and `clk_ena` are zero and any pending high byte is dropped.
- R11: `latency_word` equals (LAT_WHOLE << 10) | LAT_FRAC, with whole cycles in bits [21:10] and the fraction in 1/1024 cycle units in bits [9:0]. The default is 22'h000600, which is 1.5 cycles.
- R12: When a strobe accepts a word with enable 2'b00, `out_valid` and `out_err` are low in that strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 2 | 00 = 10M, 01 = 100M, 10/11 = 1G |
| in_data | input | 16 | Two-lane word, low lane in [7:0] |
| in_en | input | 2 | Per-lane enable |
| in_err | input | 2 | Per-lane error |
| in_ready | output | 1 | Word is taken at the coming edge |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_err | output | 1 | Output byte error |
| clk_ena | output | 1 | Speed-dependent clock-enable strobe |
| latency_word | output | 22 | Fixed-point datapath latency |

## Verification
The bench checks the byte order inside a word. It also checks that `in_ready` drops while a high byte is held; a design that got this wrong would overwrite the pending byte with the next word. It checks that the low-lane-only and high-lane-only words leave nothing pending, since a mistake there would emit a stale or phantom byte. The strobe period is measured at each rate. The distance to the first strobe after a mid-count speed change is checked, which catches a counter that is not restarted and would fire early or late. At the slow rates, the hold of data and error between strobes is checked on every cycle, along with a valid that appears only on strobe cycles.

// File: rtl/gls_pkg.sv
package gls_pkg;
  localparam logic [1:0] SPD_SLOW = 2'b00;
  localparam logic [1:0] SPD_MID  = 2'b01;
  localparam int LAT_WHOLE_W = 12;
  localparam int LAT_FRAC_W  = 10;
  localparam int LAT_W       = LAT_WHOLE_W + LAT_FRAC_W;
endpackage

// File: rtl/gls_rate_strobe.sv
module gls_rate_strobe
  import gls_pkg::*;
#(
  parameter int DIV_MID  = 10,
  parameter int DIV_SLOW = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] speed_sel,
  output logic       tick,
  output logic       strobe
);
  localparam int CNT_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;
  logic [1:0]       spd_q;
  logic             strobe_q;
  logic             changed;

  always_comb begin
    case (speed_sel)
      SPD_SLOW: last_c = CNT_W'(DIV_SLOW - 1);
      SPD_MID:  last_c = CNT_W'(DIV_MID - 1);
      default:  last_c = '0;
    endcase
  end

  assign changed = (speed_sel != spd_q);
  assign tick    = !changed && (cnt_q == last_c);
  assign strobe  = strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      spd_q    <= speed_sel;
      strobe_q <= 1'b0;
    end else begin
      spd_q    <= speed_sel;
      strobe_q <= tick;
      if (changed || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && speed_sel[1] == 1'b0) |=> !strobe_q); // R2
  AST_STROBE_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !strobe_q); // R10
  AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (speed_sel != spd_q) |=> !strobe_q); // R9
endmodule

// File: rtl/gls_word_splitter.sv
module gls_word_splitter #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [2*LANE_W-1:0] in_data,
  input  logic [1:0]        in_en,
  input  logic [1:0]        in_err,
  output logic              in_ready,
  output logic [LANE_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_err
);
  logic              hold_q;
  logic [LANE_W-1:0] hold_byte_q;
  logic              hold_err_q;
  logic [LANE_W-1:0] data_q;
  logic              valid_q;
  logic              err_q;

  assign in_ready  = tick && !hold_q;
  assign out_data  = data_q;
  assign out_valid = valid_q;
  assign out_err   = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= 1'b0;
      hold_byte_q <= '0;
      hold_err_q  <= 1'b0;
      data_q      <= '0;
      valid_q     <= 1'b0;
      err_q       <= 1'b0;
    end else if (tick) begin
      if (hold_q) begin
        data_q  <= hold_byte_q;
        valid_q <= 1'b1;
        err_q   <= hold_err_q;
        hold_q  <= 1'b0;
      end else if (in_en[0]) begin
        data_q      <= in_data[LANE_W-1:0];
        valid_q     <= 1'b1;
        err_q       <= in_err[0];
        hold_q      <= in_en[1];
        hold_byte_q <= in_data[2*LANE_W-1:LANE_W];
        hold_err_q  <= in_err[1];
      end else begin
        valid_q <= 1'b0;
        err_q   <= 1'b0;
      end
    end else begin
      valid_q <= 1'b0;
    end
  end

  AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_en == 2'b11) |=> !in_ready); // R3
  AST_VALID_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_q && !err_q)); // R10
endmodule

// File: rtl/gmii_lane_splitter.sv
module gmii_lane_splitter
  import gls_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int DIV_MID   = 10,
  parameter int DIV_SLOW  = 100,
  parameter int LAT_WHOLE = 1,
  parameter int LAT_FRAC  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        speed_sel,
  input  logic [2*LANE_W-1:0] in_data,
  input  logic [1:0]        in_en,
  input  logic [1:0]        in_err,
  output logic              in_ready,
  output logic [LANE_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_err,
  output logic              clk_ena,
  output logic [LAT_W-1:0]  latency_word
);
  localparam logic [LAT_W-1:0] LAT_CONST =
    {LAT_WHOLE_W'(LAT_WHOLE), LAT_FRAC_W'(LAT_FRAC)};

  logic tick;

  gls_rate_strobe #(
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_rate (
    .clk       (clk),
    .rst       (rst),
    .speed_sel (speed_sel),
    .tick      (tick),
    .strobe    (clk_ena)
  );

  gls_word_splitter #(
    .LANE_W (LANE_W)
  ) u_split (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .in_data   (in_data),
    .in_en     (in_en),
    .in_err    (in_err),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_err   (out_err)
  );

  assign latency_word = LAT_CONST;

  AST_VALID_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> clk_ena); // R5
  AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
    !clk_ena |-> (out_data == $past(out_data) && out_err == $past(out_err))); // R6
endmodule

// File: tb/gmii_lane_splitter_tb.sv
module gmii_lane_splitter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  speed_sel;
  logic [15:0] in_data;
  logic [1:0]  in_en;
  logic [1:0]  in_err;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_err;
  logic        clk_ena;
  logic [21:0] latency_word;

  int checks = 0;
  int fails  = 0;

  gmii_lane_splitter u_dut (
    .clk (clk), .rst (rst), .speed_sel (speed_sel),
    .in_data (in_data), .in_en (in_en), .in_err (in_err),
    .in_ready (in_ready), .out_data (out_data), .out_valid (out_valid),
    .out_err (out_err), .clk_ena (clk_ena), .latency_word (latency_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_s();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic [15:0] d, input logic [1:0] en, input logic [1:0] er);
    in_data = d; in_en = en; in_err = er;
  endtask

  task automatic t_reset();
    rst = 1'b1; speed_sel = 2'b10; drive(16'h0, 2'b00, 2'b00);
    repeat (3) edge_s();
    chk(out_valid == 0 && out_err == 0, "R10 valid/err", {out_valid, out_err}, 0);
    chk(out_data == 0, "R10 data", out_data, 0);
    chk(clk_ena == 0, "R10 clk_ena", clk_ena, 0);
    chk(latency_word == 22'h000600, "R11 latency", latency_word, 22'h000600);
    @(negedge clk); rst = 1'b0;
    edge_s();
    chk(clk_ena == 1, "R2 1G after reset", clk_ena, 1);
    @(negedge clk);
  endtask

  task automatic t_lanes_1g();
    drive(16'hB2A1, 2'b11, 2'b00);
    chk(in_ready == 1, "R3 ready idle", in_ready, 1);
    edge_s();
    chk(out_valid && out_data == 8'hA1, "R1 low first", out_data, 8'hA1);
    chk(clk_ena == 1, "R2 every cycle", clk_ena, 1);
    @(negedge clk); drive(16'hD4C3, 2'b11, 2'b00);
    chk(in_ready == 0, "R3 ready low on hold", in_ready, 0);
    edge_s();
    chk(out_valid && out_data == 8'hB2, "R1 high second", out_data, 8'hB2);
    @(negedge clk);
    chk(in_ready == 1, "R3 ready back", in_ready, 1);
    edge_s();
    chk(out_valid && out_data == 8'hC3, "R1 next low", out_data, 8'hC3);
    @(negedge clk); drive(16'h0, 2'b00, 2'b00);
    edge_s();
    chk(out_valid && out_data == 8'hD4, "R1 next high", out_data, 8'hD4);
    @(negedge clk);
    chk(in_ready == 1, "R3 ready after frame", in_ready, 1);
    edge_s();
    chk(!out_valid && !out_err, "R12 idle word", {out_valid, out_err}, 0);
    @(negedge clk);
  endtask

  task automatic t_err_1g();
    drive(16'h6655, 2'b11, 2'b10);
    edge_s();
    chk(out_valid && out_data == 8'h55 && !out_err, "R4 low lane err", {out_data, out_err}, {8'h55, 1'b0});
    @(negedge clk); drive(16'h00EE, 2'b01, 2'b01);
    edge_s();
    chk(out_valid && out_data == 8'h66 && out_err, "R4 high lane err", {out_data, out_err}, {8'h66, 1'b1});
    @(negedge clk);
    edge_s();
    chk(out_valid && out_data == 8'hEE && out_err, "R7 single byte", {out_data, out_err}, {8'hEE, 1'b1});
    @(negedge clk);
    chk(in_ready == 1, "R7 no hold after single lane", in_ready, 1);
    drive(16'h0, 2'b00, 2'b00);
    edge_s();
    chk(!out_valid && !out_err, "R12 idle after single", {out_valid, out_err}, 0);
    @(negedge clk);
  endtask

  task automatic t_upper_only();
    drive(16'h9977, 2'b10, 2'b10);
    chk(in_ready == 1, "R8 ready", in_ready, 1);
    edge_s();
    chk(!out_valid && !out_err, "R8 no byte", {out_valid, out_err}, 0);
    chk(out_data == 8'hEE, "R8 data unchanged", out_data, 8'hEE);
    @(negedge clk);
    chk(in_ready == 1, "R8 nothing pending", in_ready, 1);
    drive(16'h0, 2'b00, 2'b00);
  endtask

  task automatic t_speed(input logic [1:0] spd, input int per);
    int n = 0;
    speed_sel = spd;
    for (int i = 1; i <= per + 5; i++) begin
      edge_s();
      if (clk_ena) begin n = i; break; end
    end
    chk(n == per + 1, "R9 first strobe after change", n, per + 1);
    n = 0;
    for (int i = 1; i <= per + 5; i++) begin
      edge_s();
      if (clk_ena) begin n = i; break; end
    end
    chk(n == per, "R2 strobe period", n, per);
    @(negedge clk);
  endtask

  task automatic t_slow_word(input int per);
    drive(16'h5A4B, 2'b11, 2'b01);
    for (int i = 0; i < per + 2 && !in_ready; i++) @(negedge clk);
    chk(in_ready == 1, "R3 ready at strobe", in_ready, 1);
    edge_s();
    chk(out_valid && clk_ena && out_data == 8'h4B && out_err, "R1 slow low byte", {out_data, out_err}, {8'h4B, 1'b1});
    @(negedge clk); drive(16'h0, 2'b00, 2'b00);
    for (int k = 1; k < per; k++) begin
      edge_s();
      chk(!out_valid && !clk_ena, "R5 no valid off strobe", {out_valid, clk_ena}, 0);
      chk(out_data == 8'h4B && out_err, "R6 hold off strobe", {out_data, out_err}, {8'h4B, 1'b1});
    end
    edge_s();
    chk(out_valid && clk_ena && out_data == 8'h5A && !out_err, "R1 slow high byte", {out_data, out_err}, {8'h5A, 1'b0});
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_lanes_1g();
    t_err_1g();
    t_upper_only();
    t_speed(2'b01, 10);
    t_slow_word(10);
    t_speed(2'b00, 100);
    t_slow_word(100);
    repeat (37) @(negedge clk);
    t_speed(2'b01, 10);
    repeat (4) @(negedge clk);
    t_speed(2'b10, 1);
    t_lanes_1g();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule